// File: doc/BRIEF.md
# SPI Serial Memory Write Guard

This block is the command front end of a small serial memory that answers as an SPI slave. Its own system clock samples the chip select, serial clock and serial data pins. It decodes six one-byte instructions and shifts the status byte or stored data back out on the serial output. Writes to the byte array or to the status byte are held back until the frame closes. They take effect only if an enable latch was armed by an earlier, separate frame and the target address lies outside the region fenced off by two protection bits.

The byte array is an internal register file, by default 256 entries. Each accepted array write also appears at the block's edge as a one-cycle strobe with its address and data. The serial output is driven only while `miso_oe` is high, so a pad can tri-state it at all other times. Both clock polarities are accepted: idle-low (mode 0) and idle-high (mode 3). Each SCK high phase and each SCK low phase must last at least four system clock cycles.

Top module: `spi_wr_guard`

## Requirements
- R1: After reset the enable latch and both protection bits are 0, `miso_oe` is low and no write strobe is given.
- R2: A frame of exactly one opcode byte 0x06, ended by chip select rising, sets the enable latch. The latch reads back as bit 1 of the status byte.
- R3: If further SCK rising edges follow the 0x06 opcode in the same frame, whether a full byte or a few bits, the enable latch stays clear.
- R4: A frame with opcode 0x04 clears the enable latch.
- R5: With the enable latch clear, a status write (opcode 0x01) and an array write (opcode 0x02) are both discarded.
- R6: A status write changes only status bits 3:2 (the protection field) to bits 3:2 of its data byte. Status bits 7:4 and bit 0 always read 0. A successful status write clears the enable latch.
- R7: An array write (0x02, 16-bit address with the low bits used, then data) commits when chip select rises. It gives `mem_we` for exactly one cycle with `mem_addr` and `mem_wdata`, and clears the enable latch.
- R8: The protection field blocks array writes as follows: 00 blocks none, 01 the upper quarter, 10 the upper half and 11 the whole array. A blocked write gives no strobe and leaves the enable latch set.
- R9: If chip select rises partway through a byte of a write frame, the write is aborted and the enable latch keeps its value.
- R10: Opcode 0x05 shifts the status byte out MSB first, repeating it for every further byte of the frame. `miso_oe` is high only while a byte is being shifted out and goes low once chip select is high.
- R11: Opcode 0x03 with a 16-bit address returns the stored byte MSB first, then the following addresses in order.
- R12: All instructions behave the same in SPI mode 0 and mode 3. Input is sampled on SCK rising and output changes on SCK falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso; low means high impedance |
| mem_we | output | 1 | One-cycle strobe of an accepted array write |
| mem_addr | output | AW | Address of the accepted write |
| mem_wdata | output | 8 | Data of the accepted write |

## Verification
On every cycle the assertions check the guard itself. The latch can only rise when chip select rises, and no strobe can fire without the latch or into a fenced address. The strobe lasts one cycle and is followed by a cleared latch, the protection field never moves without the latch, and the output is quiet after deselect. Only the bench's scenarios can show that the right bytes reach the right addresses and that extra clocks after the enable opcode cancel it. They also show that partial bytes abort a write, that status and data come out serially in the right order, and that both clock polarities work.

// File: rtl/spi_wr_guard_pkg.sv
`timescale 1ns/1ps
package spi_wr_guard_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_OP, PH_AHI, PH_ALO, PH_WDATA, PH_SDATA, PH_RDOUT, PH_SOUT, PH_DRAIN
  } phase_t;

  typedef enum logic [2:0] {
    PD_NONE, PD_SET, PD_CLR, PD_STAT, PD_MEM
  } pend_t;

  // Fence test on the two top address bits.
  function automatic logic in_guard(input logic [1:0] fence, input logic [1:0] top);
    case (fence)
      2'b00:   in_guard = 1'b0;
      2'b01:   in_guard = (top == 2'b11);
      2'b10:   in_guard = top[1];
      default: in_guard = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_byte_ram.sv
`timescale 1ns/1ps
module spi_byte_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_cmd_fsm.sv
`timescale 1ns/1ps
module spi_cmd_fsm
  import spi_wr_guard_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_q,
  input  logic          sck_q,
  input  logic          mosi_q,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] rd_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          wel,
  output logic [1:0]    bp,
  output logic          miso,
  output logic          miso_oe
);
  phase_t        phase;
  pend_t         pend;
  logic          cs_p, sck_p, is_read, load_pend;
  logic [2:0]    bit_cnt;
  logic [6:0]    sr;
  logic [7:0]    sr_next, out_sr, data_buf;
  logic [1:0]    stat_buf;
  logic [AW-1:0] addr;
  logic          active, cs_rise, sck_rise, sck_fall, byte_done;
  logic [7:0]    status_byte;

  assign active      = !cs_q;
  assign cs_rise     = cs_q && !cs_p;
  assign sck_rise    = active && sck_q && !sck_p;
  assign sck_fall    = active && !sck_q && sck_p;
  assign sr_next     = {sr, mosi_q};
  assign byte_done   = sck_rise && (bit_cnt == 3'd7);
  assign status_byte = {4'b0000, bp, wel, 1'b0};
  assign miso        = out_sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= 1'b1; sck_p <= 1'b0;
      phase <= PH_OP; pend <= PD_NONE; bit_cnt <= '0; sr <= '0;
      is_read <= 1'b0; load_pend <= 1'b0; out_sr <= '0; miso_oe <= 1'b0;
      data_buf <= '0; stat_buf <= '0; addr <= '0; rd_addr <= '0;
      wel <= 1'b0; bp <= 2'b00;
      mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      cs_p   <= cs_q;
      sck_p  <= sck_q;
      mem_we <= 1'b0;
      if (cs_q) begin
        phase <= PH_OP; bit_cnt <= '0; miso_oe <= 1'b0; load_pend <= 1'b0;
        if (cs_rise) begin
          pend <= PD_NONE;
          if (bit_cnt == 3'd0) begin
            case (pend)
              PD_SET: wel <= 1'b1;
              PD_CLR: wel <= 1'b0;
              PD_STAT: if (wel) begin
                bp  <= stat_buf;
                wel <= 1'b0;
              end
              PD_MEM: if (wel && !in_guard(bp, addr[AW-1:AW-2])) begin
                mem_we    <= 1'b1;
                mem_addr  <= addr;
                mem_wdata <= data_buf;
                wel       <= 1'b0;
              end
              default: ;
            endcase
          end
        end
      end else begin
        if (sck_rise) begin
          sr      <= sr_next[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          // any clock after a latch opcode cancels it
          if (pend == PD_SET || pend == PD_CLR) pend <= PD_NONE;
          if (byte_done) begin
            case (phase)
              PH_OP: begin
                case (sr_next)
                  OP_WREN:  begin pend <= PD_SET; phase <= PH_DRAIN; end
                  OP_WRDI:  begin pend <= PD_CLR; phase <= PH_DRAIN; end
                  OP_RDSR:  begin phase <= PH_SOUT; load_pend <= 1'b1; end
                  OP_WRSR:  phase <= PH_SDATA;
                  OP_READ:  begin phase <= PH_AHI; is_read <= 1'b1; end
                  OP_WRITE: begin phase <= PH_AHI; is_read <= 1'b0; end
                  default:  phase <= PH_DRAIN;
                endcase
              end
              PH_AHI: phase <= PH_ALO;
              PH_ALO: begin
                addr <= sr_next[AW-1:0];
                if (is_read) begin
                  phase <= PH_RDOUT; load_pend <= 1'b1; rd_addr <= sr_next[AW-1:0];
                end else begin
                  phase <= PH_WDATA;
                end
              end
              PH_WDATA: begin data_buf <= sr_next; pend <= PD_MEM; end
              PH_SDATA: begin stat_buf <= sr_next[3:2]; pend <= PD_STAT; phase <= PH_DRAIN; end
              PH_SOUT:  load_pend <= 1'b1;
              PH_RDOUT: begin load_pend <= 1'b1; rd_addr <= rd_addr + 1'b1; end
              default: ;
            endcase
          end
        end
        if (sck_fall) begin
          if (load_pend) begin
            load_pend <= 1'b0;
            miso_oe   <= 1'b1;
            out_sr    <= (phase == PH_SOUT) ? status_byte : rdata;
          end else begin
            out_sr <= {out_sr[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_wr_guard.sv
`timescale 1ns/1ps
module spi_wr_guard #(
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata
);
  logic          cs_q, sck_q, mosi_q, wel;
  logic [1:0]    bp;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rdata;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .din({cs_n, sck, mosi}), .dout({cs_q, sck_q, mosi_q})
  );

  spi_cmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .cs_q(cs_q), .sck_q(sck_q), .mosi_q(mosi_q),
    .rdata(rdata), .rd_addr(rd_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .wel(wel), .bp(bp), .miso(miso), .miso_oe(miso_oe)
  );

  spi_byte_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rdata)
  );
endmodule

// File: rtl/spi_wr_guard_chk.sv
`timescale 1ns/1ps
module spi_wr_guard_chk
  import spi_wr_guard_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_q,
  input logic       wel,
  input logic [1:0] bp,
  input logic       mem_we,
  input logic [1:0] addr_hi,
  input logic       miso_oe
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!wel && bp == 2'b00 && !mem_we && !miso_oe));

  assert_wel_at_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> ($past(cs_q) && !$past(cs_q, 2)));

  assert_write_needs_wel_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(wel));

  assert_bp_needs_wel_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> $past(wel));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_wel_cleared_after_write_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !wel);

  assert_no_fenced_write_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !in_guard(bp, addr_hi));

  assert_quiet_deselected_R10: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> !miso_oe);
endmodule

bind spi_wr_guard spi_wr_guard_chk u_chk (
  .clk(clk), .rst(rst), .cs_q(cs_q), .wel(wel), .bp(bp), .mem_we(mem_we),
  .addr_hi(mem_addr[AW-1:AW-2]), .miso_oe(miso_oe)
);

// File: tb/spi_wr_guard_test.sv
`timescale 1ns/1ps
module spi_wr_guard_test;
  localparam int AW = 8;
  localparam int HALF = 8;

  typedef struct packed {
    logic       m3;
    logic [1:0] fence;
    logic [7:0] addr;
    logic [7:0] data;
    logic       ok;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 2'd0, 8'h10, 8'hA5, 1'b1},
    '{1'b1, 2'd0, 8'h11, 8'h5A, 1'b1},
    '{1'b0, 2'd1, 8'hC0, 8'h11, 1'b0},
    '{1'b1, 2'd1, 8'hBF, 8'h22, 1'b1},
    '{1'b0, 2'd2, 8'h80, 8'h33, 1'b0},
    '{1'b1, 2'd2, 8'h7F, 8'h44, 1'b1},
    '{1'b1, 2'd3, 8'h00, 8'h55, 1'b0},
    '{1'b0, 2'd3, 8'h40, 8'h66, 1'b0},
    '{1'b1, 2'd0, 8'h40, 8'h77, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic mode3 = 1'b0;
  int n_chk = 0, n_bad = 0, we_cnt = 0;
  logic [AW-1:0] we_addr = '0;
  logic [7:0] we_data = '0;

  always #2 clk = ~clk;

  spi_wr_guard #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .miso_oe(miso_oe), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) begin
    we_cnt  <= we_cnt + 1;
    we_addr <= mem_addr;
    we_data <= mem_wdata;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic begin_frame(input logic m3);
    mode3 = m3;
    sck = m3;
    repeat (8) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_frame;
    if (!mode3) begin
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xbits(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic cmd1(input logic m3, input logic [7:0] op, input int extra);
    logic [7:0] rx;
    begin_frame(m3);
    xfer(op, rx);
    xbits(extra);
    end_frame();
  endtask

  task automatic wrsr(input logic m3, input logic [7:0] v);
    logic [7:0] rx;
    begin_frame(m3);
    xfer(8'h01, rx);
    xfer(v, rx);
    end_frame();
  endtask

  task automatic status(input logic m3, output logic [7:0] s);
    logic [7:0] rx;
    begin_frame(m3);
    xfer(8'h05, rx);
    xfer(8'h00, s);
    end_frame();
  endtask

  task automatic wr(input logic m3, input logic [7:0] a, input logic [7:0] d, input int cut);
    logic [7:0] rx;
    begin_frame(m3);
    xfer(8'h02, rx);
    xfer(8'h00, rx);
    xfer(a, rx);
    if (cut == 0) xfer(d, rx);
    else xbits(cut);
    end_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, rx, r1, r2;
    int n0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 oe after reset", miso_oe, 0);
    check("R1 no strobe after reset", we_cnt, 0);
    status(0, s);
    check("R1 status after reset", s, 8'h00);

    // R5: locked writes discarded
    wr(0, 8'h20, 8'h99, 0);
    check("R5 locked array write", we_cnt, 0);
    wrsr(0, 8'h0C);
    status(0, s);
    check("R5 locked status write", s, 8'h00);

    // R2 enable, R10 repeated status and output enable
    cmd1(0, 8'h06, 0);
    begin_frame(0);
    xfer(8'h05, rx);
    xfer(8'h00, r1);
    check("R10 oe while shifting", miso_oe, 1);
    xfer(8'h00, r2);
    end_frame();
    check("R2 WEL visible", r1, 8'h02);
    check("R10 status repeats", r2, 8'h02);
    check("R10 oe after deselect", miso_oe, 0);

    // R4 disable
    cmd1(1, 8'h04, 0);
    status(1, s);
    check("R4 WRDI clears", s, 8'h00);

    // R3 extra clocks cancel enable
    cmd1(0, 8'h06, 8);
    status(0, s);
    check("R3 extra byte after WREN", s, 8'h00);
    cmd1(1, 8'h06, 3);
    status(1, s);
    check("R3 extra bits after WREN", s, 8'h00);

    // R6 only fence bits change, latch auto-clears
    cmd1(0, 8'h06, 0);
    wrsr(0, 8'hFF);
    status(0, s);
    check("R6 status write fields", s, 8'h0C);
    cmd1(0, 8'h06, 0);
    wrsr(0, 8'h00);
    status(0, s);
    check("R6 fence restored", s, 8'h00);

    // R9 partial byte aborts
    cmd1(0, 8'h06, 0);
    n0 = we_cnt;
    wr(0, 8'h20, 8'h99, 4);
    check("R9 partial byte no strobe", we_cnt - n0, 0);
    status(0, s);
    check("R9 latch kept", s, 8'h02);
    cmd1(0, 8'h04, 0);

    // table: fence, write, outcome; R8 R7 R12
    foreach (VEC[i]) begin
      cmd1(VEC[i].m3, 8'h06, 0);
      wrsr(VEC[i].m3, {4'b0, VEC[i].fence, 2'b00});
      cmd1(VEC[i].m3, 8'h06, 0);
      n0 = we_cnt;
      wr(VEC[i].m3, VEC[i].addr, VEC[i].data, 0);
      check($sformatf("R8/R12 row %0d strobe count", i), we_cnt - n0, {31'b0, VEC[i].ok});
      if (VEC[i].ok) begin
        check($sformatf("R7 row %0d addr", i), we_addr, VEC[i].addr);
        check($sformatf("R7 row %0d data", i), we_data, VEC[i].data);
      end
      status(VEC[i].m3, s);
      check($sformatf("R8 row %0d status", i), s, {4'b0, VEC[i].fence, ~VEC[i].ok, 1'b0});
    end

    // R11 sequential read, R12 in mode 3
    begin_frame(0);
    xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h10, rx);
    xfer(8'h00, r1);
    xfer(8'h00, r2);
    end_frame();
    check("R11 read first", r1, 8'hA5);
    check("R11 read next", r2, 8'h5A);
    begin_frame(1);
    xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'hBF, rx);
    xfer(8'h00, r1);
    end_frame();
    check("R12 mode 3 read", r1, 8'h22);
    begin_frame(0);
    xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h40, rx);
    xfer(8'h00, r1);
    end_frame();
    check("R11 overwritten byte", r1, 8'h77);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule